// File: doc/BRIEF.md
# Programmable three-port parallel I/O

This block is a bus-attached parallel I/O peripheral with three 8-bit ports, named A, B and C, where port C is handled as two 4-bit halves that can be pointed in different directions. A processor reaches it through an 8-bit data bus, a 2-bit register select taken from the two lowest address lines, and active-low read and write strobes. A small decoder inside the block forms the active-low chip select from the upper address lines and an active-low enable input.

A write-only control word sets the direction of port A, port B, the high half of port C and the low half of port C. Every pin is modelled as three separate signals: a pin input, an output latch value and an output enable. Writes are taken on the rising clock edge while chip select and the write strobe are both low. Reads are combinational and are valid while chip select and the read strobe are both low.

Top module: `pio3_top`

## Requirements
- R1: After reset every port enable is 0, every output latch is 0 and the data bus enable `data_oe` is 0.
- R2: `chip_sel_n` is low only when `cpu_addr[7:6]` = 2'b11 and `dec_en_n` = 0. A strobe given while `chip_sel_n` is high changes no latch.
- R3: The register select `cpu_addr[1:0]` picks the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control word. A write with chip select and `wr_n` low loads `data_in` into the chosen port latch at the next rising clock edge, and the latch drives the `*_out` pins after that edge.
- R4: A control word with bit 7 = 1 sets the directions. Bit 4 sets port A, bit 1 sets port B, bit 3 sets C[7:4] and bit 0 sets C[3:0]; 1 means input and 0 means output. An output group drives all of its enable bits as 1, and an input group drives them as 0. For example, 0x90 makes A an input and makes B and all of C outputs. Writes keep bits 6, 5 and 2 at 0.
- R5: A control write with bit 7 = 1 clears all output latches at the same edge.
- R6: A control write with bit 7 = 0 changes neither the directions nor the latches.
- R7: A read of port A, B or C returns the pin inputs for groups that are inputs and the latch values for groups that are outputs. For port C this is decided per half.
- R8: A read of register 3 returns 0xFF.
- R9: `data_oe` is 1 only while chip select and `rd_n` are both low.
- R10: A cycle with `wr_n` high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 8 | Address: upper bits drive the decoder, bits 1..0 select the register |
| dec_en_n | input | 1 | Decoder enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Data bus drive enable |
| chip_sel_n | output | 1 | Decoded chip select, active low |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Chip select, read data and `data_oe` are combinational, so they are due in the same cycle as the address and strobes. The bench drives these on the falling edge and samples 1 ns later. Latch, enable and direction changes from a write appear one rising edge later, so each write is held across exactly one rising edge and the effect is sampled at the following falling edge. The vector table mixes writes and reads in this way. Directed checks then cover direction enables, latch clearing, decode boundaries and strobe gating.

// File: rtl/pio3_pkg.sv
package pio3_pkg;

   // control word field positions (neighbouring logic decodes these)
   localparam int CW_MODE = 7;
   localparam int CW_A    = 4;
   localparam int CW_CH   = 3;
   localparam int CW_B    = 1;
   localparam int CW_CL   = 0;

   typedef enum logic [1:0] {
      SEL_A   = 2'd0,
      SEL_B   = 2'd1,
      SEL_C   = 2'd2,
      SEL_CTL = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic a_in;
      logic b_in;
      logic ch_in;
      logic cl_in;
   } dir_t;

   localparam dir_t DIR_RESET = dir_t'(4'hF);

   // nibble g: port g/2, half g%2 (0 = low half)
   function automatic logic nib_is_in(dir_t d, int unsigned g);
      case (g)
         0, 1:    return d.a_in;
         2, 3:    return d.b_in;
         4:       return d.cl_in;
         5:       return d.ch_in;
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/pio3_csdec.sv
module pio3_csdec #(
   parameter int ADDR_W = 8,
   parameter int MATCH_W = 2,
   parameter logic [MATCH_W-1:0] MATCH_VAL = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_n,
   output logic              cs_n
);

   localparam int LOW_TOP = ADDR_W - MATCH_W - 1;

   if (MATCH_W < 1 || LOW_TOP < 2) begin : g_bad_match
      $error("pio3_csdec: MATCH_W must leave at least three low address bits");
   end

   logic unused_low;
   assign unused_low = ^addr[LOW_TOP:0];

   assign cs_n = !((addr[ADDR_W-1 -: MATCH_W] == MATCH_VAL) && !en_n);

endmodule

// File: rtl/pio3_ctl.sv
module pio3_ctl
   import pio3_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output dir_t              dir,
   output logic              clr_lat
);

   assign clr_lat = we && wdata[CW_MODE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= DIR_RESET;
      end else if (clr_lat) begin
         dir <= '{a_in:  wdata[CW_A],
                  b_in:  wdata[CW_B],
                  ch_in: wdata[CW_CH],
                  cl_in: wdata[CW_CL]};
      end
   end

   // R6: a word without the mode flag leaves the directions alone
   a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[CW_MODE]) |=> $stable(dir));

   // R4: a flagged word lands in the direction fields
   a_r4_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[CW_MODE]) |=> (dir.a_in == $past(wdata[CW_A])
                                  && dir.cl_in == $past(wdata[CW_CL])));

endmodule

// File: rtl/pio3_nib.sv
module pio3_nib #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         is_in,
   input  logic         we,
   input  logic         clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin,
   output logic [W-1:0] lat,
   output logic [W-1:0] oe,
   output logic [W-1:0] rd
);

   if (W < 1) begin : g_bad_w
      $error("pio3_nib: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat <= '0;
      else if (clr)  lat <= '0;
      else if (we)   lat <= wdata;
   end

   assign oe = {W{!is_in}};
   assign rd = is_in ? pin : lat;

   // R5: a valid control word empties the latch
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lat == '0));

   // R3: a port write is visible on the latch one edge later
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> (lat == $past(wdata)));

endmodule

// File: rtl/pio3_top.sv
module pio3_top
   import pio3_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int MATCH_W = 2,
   parameter logic [MATCH_W-1:0] MATCH_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              dec_en_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              chip_sel_n,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);

   localparam int NPORT = 3;
   localparam int NIB_W = DATA_W / 2;
   localparam int NNIB  = NPORT * 2;
   localparam int PIN_W = NPORT * DATA_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("pio3_top: control word layout needs DATA_W == 8");
   end

   reg_sel_e         reg_sel;
   logic             acc_wr, acc_rd;
   dir_t             dir;
   logic             clr_lat;
   logic [PIN_W-1:0] pins_all, lat_all, oe_all, rd_all;

   pio3_csdec #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL)) u_dec (
      .addr(cpu_addr), .en_n(dec_en_n), .cs_n(chip_sel_n));

   assign reg_sel = reg_sel_e'(cpu_addr[1:0]);
   assign acc_wr  = !chip_sel_n && !wr_n;
   assign acc_rd  = !chip_sel_n && !rd_n;

   pio3_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .we(acc_wr && reg_sel == SEL_CTL), .wdata(data_in),
      .dir(dir), .clr_lat(clr_lat));

   assign pins_all = {pc_in, pb_in, pa_in};

   for (genvar g = 0; g < NNIB; g++) begin : g_nib
      localparam int P = g / 2;
      localparam int H = g % 2;
      pio3_nib #(.W(NIB_W)) u_nib (
         .clk(clk), .rst_n(rst_n),
         .is_in(nib_is_in(dir, g)),
         .we(acc_wr && cpu_addr[1:0] == 2'(P)),
         .clr(clr_lat),
         .wdata(data_in[H*NIB_W +: NIB_W]),
         .pin(pins_all[g*NIB_W +: NIB_W]),
         .lat(lat_all[g*NIB_W +: NIB_W]),
         .oe(oe_all[g*NIB_W +: NIB_W]),
         .rd(rd_all[g*NIB_W +: NIB_W]));
   end

   assign {pc_out, pb_out, pa_out} = lat_all;
   assign {pc_oe,  pb_oe,  pa_oe}  = oe_all;

   always_comb begin
      case (reg_sel)
         SEL_A:   data_out = rd_all[0*DATA_W +: DATA_W];
         SEL_B:   data_out = rd_all[1*DATA_W +: DATA_W];
         SEL_C:   data_out = rd_all[2*DATA_W +: DATA_W];
         default: data_out = '1;
      endcase
   end

   assign data_oe = acc_rd;

   // R9: the bus is never driven without a read strobe
   a_r9_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !data_oe);

   // R8: control address reads back all ones
   a_r8_ctl_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && cpu_addr[1:0] == 2'b11) |-> (data_out == '1));

   // R2: nothing latches while deselected
   a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      chip_sel_n |=> $stable(lat_all));

   // R10: no write strobe, no latch change
   a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_n |=> $stable(lat_all));

   // R4: enables move as whole groups
   a_r4_group_oe: assert property (@(posedge clk) disable iff (!rst_n)
      ((pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1)
       && ($countones(pc_oe[7:4]) == 0 || $countones(pc_oe[7:4]) == 4)
       && ($countones(pc_oe[3:0]) == 0 || $countones(pc_oe[3:0]) == 4)));

endmodule

// File: tb/pio3_top_tb.sv
`timescale 1ns/1ps
module pio3_top_tb_top;

   typedef struct packed {
      logic        wr;
      logic [1:0]  rsel;
      logic [7:0]  wd;
      logic [23:0] pins;   // {C, B, A}
      logic [7:0]  exp;
   } vec_t;

   localparam int NVEC = 21;
   localparam vec_t VECS [NVEC] = '{
      vec_t'({1'b1, 2'd3, 8'h90, 24'h000000, 8'h00}),
      vec_t'({1'b1, 2'd1, 8'h5A, 24'h000000, 8'h00}),
      vec_t'({1'b1, 2'd2, 8'hC3, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd0, 8'h00, 24'h000037, 8'h37}),
      vec_t'({1'b0, 2'd1, 8'h00, 24'h00FF00, 8'h5A}),
      vec_t'({1'b0, 2'd2, 8'h00, 24'hFF0000, 8'hC3}),
      vec_t'({1'b0, 2'd3, 8'h00, 24'h000000, 8'hFF}),
      vec_t'({1'b1, 2'd3, 8'h89, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd1, 8'h00, 24'h001100, 8'h00}),
      vec_t'({1'b0, 2'd2, 8'h00, 24'h6E0000, 8'h6E}),
      vec_t'({1'b1, 2'd3, 8'h88, 24'h000000, 8'h00}),
      vec_t'({1'b1, 2'd2, 8'hA5, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd2, 8'h00, 24'h3C0000, 8'h35}),
      vec_t'({1'b1, 2'd3, 8'h81, 24'h000000, 8'h00}),
      vec_t'({1'b1, 2'd2, 8'h9F, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd2, 8'h00, 24'h420000, 8'h92}),
      vec_t'({1'b1, 2'd3, 8'h12, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd2, 8'h00, 24'h420000, 8'h92}),
      vec_t'({1'b1, 2'd3, 8'h9B, 24'h000000, 8'h00}),
      vec_t'({1'b0, 2'd0, 8'h00, 24'h000BA0, 8'hA0}),
      vec_t'({1'b0, 2'd1, 8'h00, 24'h000BA0, 8'h0B})
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = 8'h00;
   logic       dec_en_n = 1'b1;
   logic       rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] data_in = 8'h00;
   logic [7:0] data_out;
   logic       data_oe, chip_sel_n;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pio3_top dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .dec_en_n(dec_en_n),
      .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out),
      .data_oe(data_oe), .chip_sel_n(chip_sel_n),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] rsel, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = {6'b110000, rsel};
      dec_en_n = 1'b0;
      data_in  = d;
      wr_n     = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_n     = 1'b1;
   endtask

   task automatic do_rd(input logic [1:0] rsel, input logic [7:0] exp, input string req);
      @(negedge clk);
      cpu_addr = {6'b110000, rsel};
      dec_en_n = 1'b0;
      rd_n     = 1'b0;
      #1;
      chk(req, {24'h0, data_out}, {24'h0, exp});
      chk("R9 oe during read", {31'h0, data_oe}, 32'h1);
      rd_n     = 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 oe", {8'h0, pa_oe, pb_oe, pc_oe}, 32'h0);
      chk("R1 latches", {8'h0, pa_out, pb_out, pc_out}, 32'h0);
      chk("R1 data_oe", {31'h0, data_oe}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: writes, then reads under R7 / R8
      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i].wr) begin
            do_wr(VECS[i].rsel, VECS[i].wd);
         end else begin
            {pc_in, pb_in, pa_in} = VECS[i].pins;
            do_rd(VECS[i].rsel, VECS[i].exp, (VECS[i].rsel == 2'd3) ? "R8 ctl read" : "R7 port read");
         end
      end

      // R4 direction enables
      do_wr(2'd3, 8'h90);
      chk("R4 0x90 enables", {8'h0, pa_oe, pb_oe, pc_oe}, 32'h00FFFF);
      do_wr(2'd3, 8'h88);
      chk("R4 0x88 enables", {8'h0, pa_oe, pb_oe, pc_oe}, 32'hFFFF0F);

      // R3 port write reaches pins, R5 cleared by valid control word
      do_wr(2'd0, 8'h3C);
      chk("R3 A latch", {24'h0, pa_out}, 32'h3C);
      do_wr(2'd1, 8'hE7);
      chk("R3 B latch", {24'h0, pb_out}, 32'hE7);
      do_wr(2'd3, 8'h80);
      chk("R5 latches cleared", {8'h0, pa_out, pb_out, pc_out}, 32'h0);

      // R6 unflagged control word: enables and latches kept
      do_wr(2'd2, 8'h66);
      do_wr(2'd3, 8'h1B);
      chk("R6 enables kept", {8'h0, pa_oe, pb_oe, pc_oe}, 32'hFFFFFF);
      chk("R6 latch kept", {24'h0, pc_out}, 32'h66);

      // R2 decoder
      @(negedge clk);
      cpu_addr = 8'hC0; dec_en_n = 1'b0; #1;
      chk("R2 select", {31'h0, chip_sel_n}, 32'h0);
      cpu_addr = 8'h83; #1;
      chk("R2 A6 low", {31'h0, chip_sel_n}, 32'h1);
      cpu_addr = 8'h43; #1;
      chk("R2 A7 low", {31'h0, chip_sel_n}, 32'h1);
      cpu_addr = 8'hC0; dec_en_n = 1'b1; #1;
      chk("R2 enable high", {31'h0, chip_sel_n}, 32'h1);

      // R2 deselected write ignored
      @(negedge clk);
      cpu_addr = 8'h40; dec_en_n = 1'b0; data_in = 8'h77; wr_n = 1'b0;
      @(posedge clk); @(negedge clk); wr_n = 1'b1;
      chk("R2 deselected write", {24'h0, pa_out}, 32'h00);

      // R10 no write strobe
      @(negedge clk);
      cpu_addr = 8'hC0; data_in = 8'h55;
      @(posedge clk); @(negedge clk);
      chk("R10 no strobe", {24'h0, pa_out}, 32'h00);

      // R9 bus enable gating
      chk("R9 idle", {31'h0, data_oe}, 32'h0);
      cpu_addr = 8'h40; rd_n = 1'b0; #1;
      chk("R9 deselected read", {31'h0, data_oe}, 32'h0);
      rd_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule